// File: doc/BRIEF.md
# PCI Bus Target Responder

This block sits on the target side of a shared, multiplexed address/data bus of the PCI kind. It watches for the first cycle in which FRAME# is asserted on an idle bus and captures the address and command at that point. It then decides whether this device owns the transaction. A memory access is owned when it falls inside a power-of-two memory window. An I/O access is owned when it falls inside a power-of-two I/O window. A configuration access is owned when the device select line is high.

Once it owns a transaction, the block asserts DEVSEL# with medium decode timing. Each data phase is handed to a simple local port that carries address, direction, data, byte enables and ready. TRDY# stays deasserted until that port answers. Memory bursts step the local address by one 32-bit word for each completed transfer. The block raises STOP# with a transfer after which it cannot continue: the last word of the memory window, or any I/O or configuration transfer. After the final data phase it releases the bus.

Top module: `pci_tgt_responder`

## Requirements
- R1: Out of reset DEVSEL#, TRDY# and STOP# are high (deasserted), `ad_oe` and `lp_req` are low.
- R2: Address and command are captured only in the first cycle with FRAME# low after a cycle in which FRAME# and IRDY# were both high. Values on the AD lines during data phases do not change the local address.
- R3: Only command codes 0010/0011 (I/O read/write), 0110/0111 (memory read/write) and 1010/1011 (configuration read/write) can be claimed, with bit 0 set meaning write. Every other code leaves DEVSEL# high and produces no local request.
- R4: A configuration command is claimed only when `idsel` is high and AD[1:0] = 00. The local address is then {24'b0, AD[7:2], 2'b00}, `lp_space` = 2.
- R5: A memory command is claimed only when AD[31:MEM_LOG2] matches the memory base and AD[1:0] = 00 (`lp_space` = 0). The local address starts at {AD[31:2], 2'b00} and rises by 4 after each completed transfer.
- R6: An I/O command is claimed when AD[31:IO_LOG2] matches the I/O base (`lp_space` = 1). The local address is the full 32-bit AD value, low two bits included.
- R7: DEVSEL# goes low on the second rising edge after the address phase, with TRDY# and STOP# still high. TRDY# goes low only on the edge after a cycle with `lp_req` and `lp_ready` both high.
- R8: While TRDY# or STOP# is low, DEVSEL#, TRDY# and STOP# do not change until the current data phase ends.
- R9: A data phase completes on an edge where IRDY# and TRDY# are both low. If FRAME# is high at that edge, DEVSEL#, TRDY# and STOP# are all high from the next edge.
- R10: STOP# is asserted together with TRDY# for the transfer at the last word of the memory window, and for every I/O and configuration transfer. It is never asserted otherwise.
- R11: After a completion with STOP# low and FRAME# still low, the block holds DEVSEL# and STOP# low and TRDY# high until it samples FRAME# high, then releases all three.
- R12: For reads, `ad_oe` is high and `ad_out` carries the local read data while TRDY# is low. For writes, a local request is issued only while IRDY# is low, and it carries the AD value and the inverted C/BE# as byte enables. No local request is issued while DEVSEL# is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| idsel | input | 1 | Configuration device select, active high |
| cbe_n | input | 4 | Command in address phase, byte enables (active low) in data phases |
| ad_in | input | 32 | Multiplexed address/data lines as received |
| ad_out | output | 32 | Read data driven onto the AD lines |
| ad_oe | output | 1 | Output enable for `ad_out` |
| devsel_n | output | 1 | DEVSEL#, active low |
| trdy_n | output | 1 | TRDY#, active low |
| stop_n | output | 1 | STOP#, active low |
| lp_req | output | 1 | Local port request for the current data phase |
| lp_we | output | 1 | Local port direction, 1 = write |
| lp_space | output | 2 | Local port space: 0 memory, 1 I/O, 2 configuration |
| lp_addr | output | 32 | Local port byte address |
| lp_wdata | output | 32 | Local port write data |
| lp_be | output | 4 | Local port byte enables, active high |
| lp_ready | input | 1 | Local port completes the request in this cycle |
| lp_rdata | input | 32 | Local port read data, valid with `lp_ready` |

## Verification
The bench runs a burst that reaches the top word of the memory window. A design that checks the window bound late would ask the local port for a word outside the window, and one that checks it early would raise STOP# on a word before the last. It sends configuration accesses with IDSEL low, with AD[1:0] nonzero, and with junk in AD[31:8]. A loose configuration rule would claim one of these, or pass the upper bits into the register address. It sends reads on which the initiator holds IRDY# high after TRDY# is already low. A design that restarts its wait logic would let TRDY# drop away or return stale data. It also runs a disconnect that leaves FRAME# low after STOP#, and a design that frees DEVSEL# too early or keeps it too long is caught at the cycle after the initiator lets FRAME# go.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

    typedef enum logic [1:0] {
        SP_MEM = 2'd0,
        SP_IO  = 2'd1,
        SP_CFG = 2'd2
    } space_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_DATA,
        ST_STOPWAIT
    } state_e;

    // Upper three command bits select the space; bit 0 selects write.
    localparam logic [2:0] CMD_IO_HI  = 3'b001;
    localparam logic [2:0] CMD_MEM_HI = 3'b011;
    localparam logic [2:0] CMD_CFG_HI = 3'b101;

    typedef struct packed {
        state_e      state;
        logic        bus_idle;
        logic        devsel_n;
        logic        trdy_n;
        logic        stop_n;
        space_e      space;
        logic        is_write;
        logic [31:0] rdata;
    } ctl_t;

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
    import pci_tgt_pkg::*;
#(
    parameter int          AW       = 32,
    parameter logic [31:0] MEM_BASE = 32'h8000_0000,
    parameter int          MEM_LOG2 = 6,
    parameter logic [31:0] IO_BASE  = 32'h0000_1000,
    parameter int          IO_LOG2  = 4
) (
    input  logic [AW-1:0] ad,
    input  logic [3:0]    cmd,
    input  logic          idsel,
    output logic          hit,
    output space_e        space,
    output logic          is_write,
    output logic [AW-1:0] start_addr
);

    localparam int CFG_REG_MSB = 7;

    logic cmd_io, cmd_mem, cmd_cfg;
    logic mem_hit, io_hit, cfg_hit;
    logic low_zero;

    always_comb begin
        cmd_io   = (cmd[3:1] == CMD_IO_HI);
        cmd_mem  = (cmd[3:1] == CMD_MEM_HI);
        cmd_cfg  = (cmd[3:1] == CMD_CFG_HI);
        low_zero = (ad[1:0] == 2'b00);

        mem_hit = cmd_mem && low_zero
                  && (ad[AW-1:MEM_LOG2] == MEM_BASE[AW-1:MEM_LOG2]);
        io_hit  = cmd_io && (ad[AW-1:IO_LOG2] == IO_BASE[AW-1:IO_LOG2]);
        cfg_hit = cmd_cfg && idsel && low_zero;

        hit      = mem_hit || io_hit || cfg_hit;
        is_write = cmd[0];

        if (cfg_hit) begin
            space      = SP_CFG;
            start_addr = '0;
            start_addr[CFG_REG_MSB:2] = ad[CFG_REG_MSB:2];
        end else if (io_hit) begin
            space      = SP_IO;
            start_addr = ad;
        end else begin
            space      = SP_MEM;
            start_addr = {ad[AW-1:2], 2'b00};
        end
    end

endmodule

// File: rtl/pci_tgt_addr.sv
module pci_tgt_addr #(
    parameter int AW       = 32,
    parameter int MEM_LOG2 = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic          at_end
);

    localparam logic [AW-1:0] WORD_BYTES = AW'(4);

    logic [AW-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load) begin
            addr_d = load_addr;
        end else if (step) begin
            addr_d = addr_q + WORD_BYTES;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr   = addr_q;
    assign at_end = &addr_q[MEM_LOG2-1:2];

endmodule

// File: rtl/pci_tgt_responder.sv
module pci_tgt_responder
    import pci_tgt_pkg::*;
#(
    parameter logic [31:0] MEM_BASE = 32'h8000_0000,
    parameter int          MEM_LOG2 = 6,
    parameter logic [31:0] IO_BASE  = 32'h0000_1000,
    parameter int          IO_LOG2  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic        idsel,
    input  logic [3:0]  cbe_n,
    input  logic [31:0] ad_in,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    output logic        devsel_n,
    output logic        trdy_n,
    output logic        stop_n,
    output logic        lp_req,
    output logic        lp_we,
    output logic [1:0]  lp_space,
    output logic [31:0] lp_addr,
    output logic [31:0] lp_wdata,
    output logic [3:0]  lp_be,
    input  logic        lp_ready,
    input  logic [31:0] lp_rdata
);

    localparam int AW = 32;

    ctl_t q, d;

    logic          dec_hit;
    space_e        dec_space;
    logic          dec_write;
    logic [AW-1:0] dec_addr;
    logic [AW-1:0] cur_addr;
    logic          at_end;

    logic addr_phase, claim, xfer_done, step_mem, lp_hs, last_word;

    pci_tgt_decode #(
        .AW       (AW),
        .MEM_BASE (MEM_BASE),
        .MEM_LOG2 (MEM_LOG2),
        .IO_BASE  (IO_BASE),
        .IO_LOG2  (IO_LOG2)
    ) u_dec (
        .ad         (ad_in),
        .cmd        (cbe_n),
        .idsel      (idsel),
        .hit        (dec_hit),
        .space      (dec_space),
        .is_write   (dec_write),
        .start_addr (dec_addr)
    );

    pci_tgt_addr #(
        .AW       (AW),
        .MEM_LOG2 (MEM_LOG2)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (claim),
        .load_addr (dec_addr),
        .step      (step_mem),
        .addr      (cur_addr),
        .at_end    (at_end)
    );

    // Handshake terms shared by the next-state logic and the outputs.
    always_comb begin
        addr_phase = (q.state == ST_IDLE) && !frame_n && q.bus_idle;
        claim      = addr_phase && dec_hit;
        xfer_done  = (q.state == ST_DATA) && !q.trdy_n && !irdy_n;
        step_mem   = xfer_done && (q.space == SP_MEM);
        lp_req     = (q.state == ST_DATA) && q.trdy_n && (!q.is_write || !irdy_n);
        lp_hs      = lp_req && lp_ready;
        last_word  = (q.space != SP_MEM) || at_end;
    end

    // Next-state computation.
    always_comb begin
        d          = q;
        d.bus_idle = frame_n && irdy_n;

        unique case (q.state)
            ST_IDLE: begin
                if (claim) begin
                    d.state    = ST_DECODE;
                    d.space    = dec_space;
                    d.is_write = dec_write;
                end
            end

            ST_DECODE: begin
                d.state    = ST_DATA;
                d.devsel_n = 1'b0;
            end

            ST_DATA: begin
                if (lp_hs) begin
                    d.trdy_n = 1'b0;
                    d.stop_n = !last_word;
                    if (!q.is_write) begin
                        d.rdata = lp_rdata;
                    end
                end else if (xfer_done) begin
                    d.trdy_n = 1'b1;
                    if (frame_n) begin
                        d.state    = ST_IDLE;
                        d.devsel_n = 1'b1;
                        d.stop_n   = 1'b1;
                    end else if (!q.stop_n) begin
                        d.state = ST_STOPWAIT;
                    end
                end
            end

            ST_STOPWAIT: begin
                if (frame_n) begin
                    d.state    = ST_IDLE;
                    d.devsel_n = 1'b1;
                    d.stop_n   = 1'b1;
                end
            end

            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state:    ST_IDLE,
                   bus_idle: 1'b1,
                   devsel_n: 1'b1,
                   trdy_n:   1'b1,
                   stop_n:   1'b1,
                   space:    SP_MEM,
                   is_write: 1'b0,
                   rdata:    '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        devsel_n = q.devsel_n;
        trdy_n   = q.trdy_n;
        stop_n   = q.stop_n;
        ad_out   = q.rdata;
        ad_oe    = (q.state == ST_DATA) && !q.is_write;
        lp_we    = q.is_write;
        lp_space = q.space;
        lp_addr  = cur_addr;
        lp_wdata = ad_in;
        lp_be    = ~cbe_n;
    end

endmodule

// File: rtl/pci_tgt_checker.sv
module pci_tgt_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        frame_n,
    input logic        irdy_n,
    input logic        devsel_n,
    input logic        trdy_n,
    input logic        stop_n,
    input logic        ad_oe,
    input logic        lp_req,
    input logic        lp_ready,
    input logic [1:0]  lp_space,
    input logic [31:0] lp_addr
);

    // R8: handshake lines frozen while a phase with TRDY#/STOP# is open
    a_r8_hold_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        ((!trdy_n || !stop_n) && !(!irdy_n && !trdy_n) && !(!stop_n && frame_n))
        |=> ($stable(devsel_n) && $stable(trdy_n) && $stable(stop_n)));

    // R7: TRDY# only inside a claimed transaction
    a_r7_trdy_needs_devsel: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n);

    // R7: DEVSEL# leads, TRDY# and STOP# follow
    a_r7_devsel_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n) |-> (trdy_n && stop_n));

    // R7: TRDY# follows a local handshake
    a_r7_trdy_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(trdy_n) |-> $past(lp_req && lp_ready));

    // R9: final completion releases the bus
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!irdy_n && !trdy_n && frame_n) |=> (devsel_n && trdy_n && stop_n));

    // R12: no local traffic and no AD drive unless claimed
    a_r12_req_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        lp_req |-> !devsel_n);

    a_r12_oe_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> !devsel_n);

    // R4: configuration register address confined to AD[7:2]
    a_r4_cfg_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_req && lp_space == 2'd2) |-> (lp_addr[31:8] == 24'd0 && lp_addr[1:0] == 2'b00));

    // R5: memory requests stay word aligned
    a_r5_mem_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_req && lp_space == 2'd0) |-> (lp_addr[1:0] == 2'b00));

endmodule

bind pci_tgt_responder pci_tgt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_n  (frame_n),
    .irdy_n   (irdy_n),
    .devsel_n (devsel_n),
    .trdy_n   (trdy_n),
    .stop_n   (stop_n),
    .ad_oe    (ad_oe),
    .lp_req   (lp_req),
    .lp_ready (lp_ready),
    .lp_space (lp_space),
    .lp_addr  (lp_addr)
);

// File: tb/pci_tgt_responder_tb.sv
module pci_tgt_responder_tb;

    logic        clk;
    logic        rst_n;
    logic        frame_n, irdy_n, idsel;
    logic [3:0]  cbe_n;
    logic [31:0] ad_in;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n, trdy_n, stop_n;
    logic        lp_req, lp_we;
    logic [1:0]  lp_space;
    logic [31:0] lp_addr, lp_wdata;
    logic [3:0]  lp_be;
    logic        lp_ready;
    logic [31:0] lp_rdata;

    int checks = 0;
    int errors = 0;
    int lp_wait = 0;
    int wait_cnt = 0;
    bit finished = 0;

    typedef struct {
        logic [1:0]  sp;
        logic        we;
        logic [31:0] addr;
        logic [31:0] data;
    } exp_t;

    exp_t exp_q[$];
    exp_t mon_e;

    pci_tgt_responder u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .frame_n  (frame_n),
        .irdy_n   (irdy_n),
        .idsel    (idsel),
        .cbe_n    (cbe_n),
        .ad_in    (ad_in),
        .ad_out   (ad_out),
        .ad_oe    (ad_oe),
        .devsel_n (devsel_n),
        .trdy_n   (trdy_n),
        .stop_n   (stop_n),
        .lp_req   (lp_req),
        .lp_we    (lp_we),
        .lp_space (lp_space),
        .lp_addr  (lp_addr),
        .lp_wdata (lp_wdata),
        .lp_be    (lp_be),
        .lp_ready (lp_ready),
        .lp_rdata (lp_rdata)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    function automatic logic [31:0] rd_pat(input logic [31:0] a);
        return a ^ 32'h5A5A_C3C3;
    endfunction

    function automatic logic [31:0] wr_pat(input int k);
        return 32'hC0DE_0000 + 32'(k) * 32'h0001_0101;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Local port model and scoreboard monitor.
    always begin
        @(negedge clk);
        #2;
        if (lp_req) begin
            if (wait_cnt == lp_wait) begin
                lp_ready = 1'b1;
                lp_rdata = rd_pat(lp_addr);
                wait_cnt = 0;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected local request", lp_addr, 32'h0);
                end else begin
                    mon_e = exp_q.pop_front();
                    chk(lp_space == mon_e.sp, "R5/R6/R4", "local space",
                        32'(lp_space), 32'(mon_e.sp));
                    chk(lp_we == mon_e.we, "R3", "local direction",
                        32'(lp_we), 32'(mon_e.we));
                    if (mon_e.sp == 2'd2)
                        chk(lp_addr == mon_e.addr, "R4", "config address", lp_addr, mon_e.addr);
                    else if (mon_e.sp == 2'd1)
                        chk(lp_addr == mon_e.addr, "R6", "io address", lp_addr, mon_e.addr);
                    else
                        chk(lp_addr == mon_e.addr, "R5", "memory address", lp_addr, mon_e.addr);
                    if (mon_e.we) begin
                        chk(lp_wdata == mon_e.data, "R12", "write data", lp_wdata, mon_e.data);
                        chk(lp_be == 4'hF, "R12", "byte enables", 32'(lp_be), 32'hF);
                    end
                end
            end else begin
                lp_ready = 1'b0;
                wait_cnt++;
            end
        end else begin
            lp_ready = 1'b0;
            wait_cnt = 0;
        end
    end

    // One initiator transaction. exp_base is the first expected local address.
    task automatic bus_txn(input logic [3:0] cmd, input logic [31:0] addr,
                           input bit sel, input int nwords, input bit claim,
                           input logic [1:0] sp, input logic [31:0] exp_base,
                           input int n_xfer, input int stop_at, input int irdy_wait);
        bit   we;
        int   step;
        int   i;
        int   cyc;
        int   waits;
        bit   pend_final, pend_stop, pend_rel, pend_next, seen_trdy;
        exp_t e;

        we   = cmd[0];
        step = (sp == 2'd0) ? 4 : 0;
        if (claim) begin
            for (int k = 0; k < n_xfer; k++) begin
                e.sp   = sp;
                e.we   = we;
                e.addr = exp_base + 32'(step * k);
                e.data = wr_pat(k);
                exp_q.push_back(e);
            end
        end

        // address phase
        @(negedge clk);
        frame_n = 1'b0;
        ad_in   = addr;
        cbe_n   = cmd;
        idsel   = sel;

        // first data cycle
        @(negedge clk);
        idsel = 1'b0;
        cbe_n = 4'b0000;
        ad_in = we ? wr_pat(0) : 32'hFFFF_0000;
        chk(devsel_n == 1'b1, "R7", "DEVSEL# one cycle after address", 32'(devsel_n), 32'h1);

        if (!claim) begin
            frame_n = 1'b1;
            irdy_n  = 1'b0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                chk(devsel_n && trdy_n && stop_n, "R3", "unclaimed transaction responded",
                    {29'd0, devsel_n, trdy_n, stop_n}, 32'h7);
            end
            irdy_n = 1'b1;
            ad_in  = 32'h0;
            @(negedge clk);
            return;
        end

        frame_n    = (nwords == 1);
        waits      = irdy_wait;
        irdy_n     = (irdy_wait > 0);
        i          = 0;
        cyc        = 0;
        pend_final = 0;
        pend_stop  = 0;
        pend_rel   = 0;
        pend_next  = 0;
        seen_trdy  = 0;

        forever begin
            @(negedge clk);
            cyc++;
            if (cyc > 200) begin
                chk(1'b0, "R9", "transaction never finished", 32'(cyc), 32'd0);
                frame_n = 1'b1;
                irdy_n  = 1'b1;
                break;
            end
            if (pend_final) begin
                irdy_n = 1'b1;
                chk(devsel_n && trdy_n && stop_n && !ad_oe, "R9", "release after final phase",
                    {28'd0, devsel_n, trdy_n, stop_n, ad_oe}, 32'hE);
                break;
            end
            if (pend_rel) begin
                chk(devsel_n && trdy_n && stop_n, "R11", "release after FRAME# high",
                    {29'd0, devsel_n, trdy_n, stop_n}, 32'h7);
                break;
            end
            if (pend_stop) begin
                chk(!devsel_n && trdy_n && !stop_n, "R11", "disconnect hold",
                    {29'd0, devsel_n, trdy_n, stop_n}, 32'h2);
                frame_n  = 1'b1;
                irdy_n   = 1'b1;
                pend_rel = 1;
                continue;
            end
            if (pend_next) begin
                pend_next = 0;
                if (we) ad_in = wr_pat(i);
                else    ad_in = 32'hFFFF_0000 + 32'(i);
                if (i == nwords - 1) frame_n = 1'b1;
            end
            if (waits > 0) begin
                waits--;
                if (waits == 0) irdy_n = 1'b0;
            end
            if (cyc == 1)
                chk(devsel_n == 1'b0, "R7", "DEVSEL# at second edge", 32'(devsel_n), 32'h0);
            if (!trdy_n && !seen_trdy) begin
                seen_trdy = 1;
                chk(cyc == 2 + lp_wait, "R7", "first TRDY# cycle", 32'(cyc), 32'(2 + lp_wait));
            end
            if (!irdy_n && !trdy_n) begin
                if (!we) begin
                    chk(ad_oe == 1'b1, "R12", "read AD drive", 32'(ad_oe), 32'h1);
                    chk(ad_out == rd_pat(exp_base + 32'(step * i)), "R12", "read data",
                        ad_out, rd_pat(exp_base + 32'(step * i)));
                end
                i++;
                chk((!stop_n) == (i == stop_at), "R10", "STOP# with transfer",
                    32'(!stop_n), 32'(i == stop_at));
                if (frame_n)      pend_final = 1;
                else if (!stop_n) pend_stop  = 1;
                else              pend_next  = 1;
            end
        end
        ad_in = 32'h0;
        cbe_n = 4'hF;
        chk(i == n_xfer, "R5", "transfer count", 32'(i), 32'(n_xfer));
        chk(exp_q.size() == 0, "R12", "pending local requests", 32'(exp_q.size()), 32'h0);
        @(negedge clk);
    endtask

    initial begin
        rst_n    = 1'b0;
        frame_n  = 1'b1;
        irdy_n   = 1'b1;
        idsel    = 1'b0;
        cbe_n    = 4'hF;
        ad_in    = 32'h0;
        lp_ready = 1'b0;
        lp_rdata = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(devsel_n && trdy_n && stop_n, "R1", "handshake idle after reset",
            {29'd0, devsel_n, trdy_n, stop_n}, 32'h7);
        chk(!ad_oe && !lp_req, "R1", "no drive and no request after reset",
            {30'd0, ad_oe, lp_req}, 32'h0);

        // R5 memory write burst, no local wait
        lp_wait = 0;
        bus_txn(4'b0111, 32'h8000_0010, 0, 4, 1, 2'd0, 32'h8000_0010, 4, 0, 0);
        // R5 R2 memory read burst with local waits and junk on AD
        lp_wait = 2;
        bus_txn(4'b0110, 32'h8000_0020, 0, 3, 1, 2'd0, 32'h8000_0020, 3, 0, 0);
        // R10 R11 memory read that hits the window end
        lp_wait = 0;
        bus_txn(4'b0110, 32'h8000_0034, 0, 4, 1, 2'd0, 32'h8000_0034, 3, 3, 0);
        // R10 single write at the last window word
        bus_txn(4'b0111, 32'h8000_003C, 0, 1, 1, 2'd0, 32'h8000_003C, 1, 1, 0);
        // R6 single I/O write with nonzero low address bits
        lp_wait = 1;
        bus_txn(4'b0011, 32'h0000_1006, 0, 1, 1, 2'd1, 32'h0000_1006, 1, 1, 0);
        // R6 R11 I/O read burst is disconnected after one word
        lp_wait = 0;
        bus_txn(4'b0010, 32'h0000_100C, 0, 2, 1, 2'd1, 32'h0000_100C, 1, 1, 0);
        // R4 R8 config read with junk upper bits, initiator waits after TRDY#
        bus_txn(4'b1010, 32'hABCD_0124, 1, 1, 1, 2'd2, 32'h0000_0024, 1, 1, 3);
        // R4 config write to the top register
        bus_txn(4'b1011, 32'h0000_00FC, 1, 1, 1, 2'd2, 32'h0000_00FC, 1, 1, 0);
        // R4 not claimed: IDSEL low, then AD[1:0] nonzero
        bus_txn(4'b1010, 32'h0000_0024, 0, 1, 0, 2'd2, 32'h0, 0, 0, 0);
        bus_txn(4'b1010, 32'h0000_0025, 1, 1, 0, 2'd2, 32'h0, 0, 0, 0);
        // R3 unsupported commands at a matching memory address
        bus_txn(4'b0100, 32'h8000_0000, 0, 1, 0, 2'd0, 32'h0, 0, 0, 0);
        bus_txn(4'b1100, 32'h8000_0000, 0, 1, 0, 2'd0, 32'h0, 0, 0, 0);
        // R5 R6 outside windows or misaligned
        bus_txn(4'b0110, 32'h8000_0040, 0, 1, 0, 2'd0, 32'h0, 0, 0, 0);
        bus_txn(4'b0110, 32'h8000_0002, 0, 1, 0, 2'd0, 32'h0, 0, 0, 0);
        bus_txn(4'b0010, 32'h0000_1010, 0, 1, 0, 2'd1, 32'h0, 0, 0, 0);
        // R8 R9 memory read with initiator and local waits
        lp_wait = 1;
        bus_txn(4'b0110, 32'h8000_0000, 0, 2, 1, 2'd0, 32'h8000_0000, 2, 0, 2);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R9 watchdog expired: actual %0d expected %0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule